// File: doc/BRIEF.md
# Brick Wall State Store

This block holds the present/absent state of every brick in a wall for a ball-and-paddle wall-breaking game. Each brick row lives in its own recirculating shift register. All row registers advance by one position on every brick-width column step, so the bit at the head of each register always belongs to the column under the beam. A line counter, cleared by a frame strobe and advanced by a line strobe, picks which row is on screen: the wall spans a band of lines, and each row owns an equal slice of that band.

Each row stores more positions than the playfield shows. The last position lies past the right edge. It is never displayed and is cleared on every pass. The middle position is only lit when the active game mode asks for a thicker wall. A wall-reset pin restores bricks only while the beam is inside the wall band. A reset that is held for just part of a frame therefore restores only the rows that were scanned while it was held. A ball-collision pulse removes the brick under the beam and raises a one-cycle hit flag. Every input acts only on cycles where the pixel enable is high.

The interface has no streaming data path. Every pin is a plain level or strobe, and there is no back-pressure.

Top module: `brk_wall`

## Requirements
- R1: The wall has 6 rows of 10 positions, numbered 0 to 9 from the left. Line L is in the wall band when 4 <= L < 16, and it shows row (L-4)/2. `brick_vid` equals the stored bit of that row at the current column. Outside the band it is 0.
- R2: Position 9 is never shown. Every pass over column 9 writes it empty in all six rows, and a collision there raises no hit flag.
- R3: When `wall_reset` is high at a column step inside the band, the shown row's bit at that column becomes 1. This applies to every column except 4 and 9.
- R4: Under the same condition, column 4 takes the value of `mid_fill`.
- R5: `wall_reset` has no effect outside the band. A reset held over only some band lines restores only the rows shown on those lines.
- R6: A `ball_hit` pulse while `brick_vid` is 1 raises `hit_flag` on the next cycle. It clears that brick when the column steps on. No other bit changes.
- R7: A `ball_hit` pulse while `brick_vid` is 0 (empty brick, or outside the band) changes nothing and leaves `hit_flag` low.
- R8: A change of `mid_fill` without a reset leaves the stored middle-column bits as they were.
- R9: After `rst_n` goes low, all bricks are empty, the line and column counters are 0, and `hit_flag` is 0.
- R10: While `pix_en` is low, strobes and pulses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous block reset |
| pix_en | input | 1 | Pixel clock enable gating all other inputs |
| col_step | input | 1 | Brick-width horizontal strobe; rotates the rows |
| line_strobe | input | 1 | Start of next scanline |
| frame_strobe | input | 1 | Start of frame; line counter to 0 |
| ball_hit | input | 1 | Ball-collision pulse |
| wall_reset | input | 1 | Game reset pin; restores bricks inside the band |
| mid_fill | input | 1 | Game-mode bit: middle column filled on reset |
| brick_vid | output | 1 | Brick video for the current beam position |
| hit_flag | output | 1 | One-cycle flag for a collision with a present brick |

## Verification
The bench checks the video bit at every column of every line over many frames. It starts with an empty wall after power-up. It then runs a full-band reset with `mid_fill` low, which should give a wall with a gap in the middle. Next, a partial reset with `mid_fill` high should fill only the upper three rows and their middle bricks. A following frame with the mode bit dropped shows that those middle bricks stay. Collision pulses are aimed at a present brick, at the same spot once it is empty, at the hidden column and at a line above the wall. These four cases separate a real clear-and-flag from a flag with no clear and from a hit on a position that must not respond. A burst of strobes with the enable low tests that disabled cycles do not move the column alignment.

// File: rtl/brk_pkg.sv
package brk_pkg;
  localparam int unsigned BRK_ROWS = 6;
  localparam int unsigned BRK_COLS = 10;

  typedef enum logic [1:0] {
    WR_KEEP  = 2'd0,
    WR_HIDE  = 2'd1,
    WR_LOAD  = 2'd2,
    WR_CLEAR = 2'd3
  } wr_src_e;
endpackage

// File: rtl/brk_raster.sv
module brk_raster #(
  parameter int unsigned COLS      = 10,
  parameter int unsigned ROWS      = 6,
  parameter int unsigned MID_COL   = 4,
  parameter int unsigned WALL_TOP  = 4,
  parameter int unsigned ROW_LINES = 2,
  parameter int unsigned LINE_W    = 9,
  localparam int unsigned COL_W    = $clog2(COLS),
  localparam int unsigned ROW_W    = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             line_stb,
  input  logic             frame_stb,
  output logic [COL_W-1:0] col_o,
  output logic [ROW_W-1:0] row_o,
  output logic             in_wall_o,
  output logic             at_hidden_o,
  output logic             at_mid_o
);
  localparam int unsigned WALL_END = WALL_TOP + ROWS * ROW_LINES;

  logic [LINE_W-1:0] line_q;
  logic [COL_W-1:0]  col_q;
  logic [LINE_W-1:0] rel_line;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (frame_stb) begin
      line_q <= '0;
      col_q  <= '0;
    end else if (line_stb) begin
      if (line_q != {LINE_W{1'b1}}) line_q <= line_q + 1'b1;
      col_q <= '0;
    end else if (step) begin
      col_q <= (col_q == COL_W'(COLS - 1)) ? '0 : col_q + 1'b1;
    end
  end

  assign rel_line    = line_q - LINE_W'(WALL_TOP);
  assign in_wall_o   = (line_q >= LINE_W'(WALL_TOP)) && (line_q < LINE_W'(WALL_END));
  assign row_o       = ROW_W'(rel_line / LINE_W'(ROW_LINES));
  assign col_o       = col_q;
  assign at_hidden_o = (col_q == COL_W'(COLS - 1));
  assign at_mid_o    = (col_q == COL_W'(MID_COL));

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= COL_W'(COLS - 1)) else $error("column out of range"); // R1
  AST_COL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !line_stb && !frame_stb) |=> $stable(col_q)) else $error("column moved"); // R10
endmodule

// File: rtl/brk_row.sv
module brk_row
  import brk_pkg::*;
#(
  parameter int unsigned COLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic active,
  input  logic at_hidden,
  input  logic at_mid,
  input  logic load,
  input  logic mid_fill,
  input  logic clr,
  output logic bit_o
);
  logic [COLS-1:0] sr_q;
  wr_src_e         src;
  logic            new_bit;

  always_comb begin
    if (at_hidden)            src = WR_HIDE;
    else if (active && load)  src = WR_LOAD;
    else if (active && clr)   src = WR_CLEAR;
    else                      src = WR_KEEP;
  end

  always_comb begin
    case (src)
      WR_HIDE:  new_bit = 1'b0;
      WR_LOAD:  new_bit = at_mid ? mid_fill : 1'b1;
      WR_CLEAR: new_bit = 1'b0;
      default:  new_bit = sr_q[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    sr_q <= '0;
    else if (step) sr_q <= {new_bit, sr_q[COLS-1:1]};
  end

  assign bit_o = sr_q[0];

  AST_HIDDEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (step && at_hidden) |=> !sr_q[COLS-1]) else $error("hidden set"); // R2
  AST_LOAD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && load && !at_hidden && !at_mid) |=> sr_q[COLS-1]) else $error("load"); // R3
  AST_MID_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (step && active && load && at_mid && !at_hidden) |=> (sr_q[COLS-1] == $past(mid_fill)))
    else $error("mid"); // R4
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(sr_q)) else $error("row moved"); // R10
endmodule

// File: rtl/brk_wall.sv
module brk_wall
  import brk_pkg::*;
#(
  parameter int unsigned ROWS      = BRK_ROWS,
  parameter int unsigned COLS      = BRK_COLS,
  parameter int unsigned MID_COL   = 4,
  parameter int unsigned WALL_TOP  = 4,
  parameter int unsigned ROW_LINES = 2,
  parameter int unsigned LINE_W    = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pix_en,
  input  logic col_step,
  input  logic line_strobe,
  input  logic frame_strobe,
  input  logic ball_hit,
  input  logic wall_reset,
  input  logic mid_fill,
  output logic brick_vid,
  output logic hit_flag
);
  localparam int unsigned COL_W = $clog2(COLS);
  localparam int unsigned ROW_W = $clog2(ROWS);

  logic             step, line_stb, frame_stb, hit_now, hit_pend_q, hit_q;
  logic [COL_W-1:0] col;
  logic [ROW_W-1:0] row;
  logic             in_wall, at_hidden, at_mid, load;
  logic [ROWS-1:0]  row_bits;

  assign step      = pix_en && col_step;
  assign line_stb  = pix_en && line_strobe;
  assign frame_stb = pix_en && frame_strobe;
  assign load      = wall_reset && in_wall;

  brk_raster #(
    .COLS(COLS), .ROWS(ROWS), .MID_COL(MID_COL), .WALL_TOP(WALL_TOP),
    .ROW_LINES(ROW_LINES), .LINE_W(LINE_W)
  ) u_raster (
    .clk(clk), .rst_n(rst_n), .step(step), .line_stb(line_stb), .frame_stb(frame_stb),
    .col_o(col), .row_o(row), .in_wall_o(in_wall), .at_hidden_o(at_hidden), .at_mid_o(at_mid)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    brk_row #(.COLS(COLS)) u_row (
      .clk(clk), .rst_n(rst_n), .step(step),
      .active(in_wall && (row == ROW_W'(r))),
      .at_hidden(at_hidden), .at_mid(at_mid), .load(load), .mid_fill(mid_fill),
      .clr(hit_pend_q || hit_now), .bit_o(row_bits[r])
    );
  end

  assign brick_vid = in_wall && !at_hidden && row_bits[row];
  assign hit_now   = pix_en && ball_hit && brick_vid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_pend_q <= 1'b0;
      hit_q      <= 1'b0;
    end else begin
      hit_q <= hit_now;
      if (step || line_stb || frame_stb) hit_pend_q <= 1'b0;
      else if (hit_now)                  hit_pend_q <= 1'b1;
    end
  end

  assign hit_flag = hit_q;

  AST_HIT_IN_WALL: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag |-> $past(in_wall && ball_hit)) else $error("stray hit"); // R6
  AST_HIT_NOT_HIDDEN: assert property (@(posedge clk) disable iff (!rst_n)
    hit_flag |-> !$past(at_hidden)) else $error("hidden hit"); // R2
endmodule

// File: tb/brk_wall_tb.sv
module brk_wall_tb;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, pix_en, col_step, line_strobe, frame_strobe, ball_hit, wall_reset, mid_fill;
  logic brick_vid, hit_flag;

  brk_wall u_dut (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en), .col_step(col_step),
    .line_strobe(line_strobe), .frame_strobe(frame_strobe), .ball_hit(ball_hit),
    .wall_reset(wall_reset), .mid_fill(mid_fill), .brick_vid(brick_vid), .hit_flag(hit_flag)
  );

  typedef struct {
    logic  vid;
    logic  hit;
    string tag;
    int    line;
    int    col;
  } item_t;

  item_t sb[$];
  bit    mon_req = 1'b0;
  bit    done    = 1'b0;
  int    checks  = 0;
  int    errors  = 0;
  bit    model[6][10];

  // monitor: pops one expected item per request, away from the active edge
  always @(negedge clk) begin
    item_t it;
    if (mon_req && sb.size() > 0) begin
      it = sb.pop_front();
      checks += 2;
      if (brick_vid !== it.vid) begin
        errors++;
        $display("FAIL %s vid line %0d col %0d actual=%b expected=%b",
                 it.tag, it.line, it.col, brick_vid, it.vid);
      end
      if (hit_flag !== it.hit) begin
        errors++;
        $display("FAIL %s hit line %0d col %0d actual=%b expected=%b",
                 it.tag, it.line, it.col, hit_flag, it.hit);
      end
    end
  end

  task automatic run_line(input int l, input bit rst, input int hcol, input string tag);
    bit inband = (l >= 4) && (l < 16);
    int row = inband ? (l - 4) / 2 : 0;
    for (int c = 0; c < 10; c++) begin
      bit vis, hh;
      item_t it;
      @(negedge clk); #1;
      vis = inband && (c != 9) && model[row][c];
      hh  = (c == hcol);
      ball_hit = hh; col_step = 1'b0; wall_reset = rst;
      it.vid = vis; it.hit = hh && vis; it.tag = tag; it.line = l; it.col = c;
      sb.push_back(it);
      mon_req = 1'b1;
      @(negedge clk); #1;
      mon_req = 1'b0; ball_hit = 1'b0; col_step = 1'b1;
      if (c == 9) begin
        for (int r = 0; r < 6; r++) model[r][9] = 1'b0;  // R2
      end else if (inband) begin
        if (rst) model[row][c] = (c == 4) ? mid_fill : 1'b1;  // R3 R4
        else if (hh && vis) model[row][c] = 1'b0;             // R6
      end
    end
    @(negedge clk); #1;
    col_step = 1'b0; line_strobe = 1'b1;
    @(negedge clk); #1;
    line_strobe = 1'b0; wall_reset = 1'b0;
  endtask

  task automatic run_frame(input int rlo, input int rhi, input int hl, input int hc,
                           input string tag);
    @(negedge clk); #1;
    frame_strobe = 1'b1;
    @(negedge clk); #1;
    frame_strobe = 1'b0;
    for (int l = 0; l < 18; l++)
      run_line(l, (l >= rlo) && (l < rhi), (l == hl) ? hc : -1, tag);
  endtask

  initial begin
    #1200000;
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 6; r++)
      for (int c = 0; c < 10; c++) model[r][c] = 1'b0;
    rst_n = 1'b0; pix_en = 1'b1; col_step = 1'b0; line_strobe = 1'b0;
    frame_strobe = 1'b0; ball_hit = 1'b0; wall_reset = 1'b0; mid_fill = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (brick_vid !== 1'b0 || hit_flag !== 1'b0) begin
      errors++;
      $display("FAIL R9 reset outputs actual=%b%b expected=00", brick_vid, hit_flag);
    end

    run_frame(-1, -1, -1, -1, "R9");       // empty wall after reset
    run_frame(4, 16, -1, -1, "R3");        // full reset, middle empty
    run_frame(-1, -1, -1, -1, "R1");       // wall shown row by row
    run_frame(-1, -1, 6, 2, "R6");         // hit present brick row 1 col 2
    run_frame(-1, -1, 6, 2, "R7");         // same spot now empty
    run_frame(-1, -1, 8, 9, "R2");         // hidden column hit
    run_frame(-1, -1, 1, 3, "R7");         // hit above the wall

    // R10: disabled cycles with strobes must not move anything
    @(negedge clk); #1;
    pix_en = 1'b0; col_step = 1'b1; ball_hit = 1'b1; wall_reset = 1'b1;
    repeat (3) @(negedge clk);
    #1 line_strobe = 1'b1; frame_strobe = 1'b1;
    @(negedge clk); #1;
    col_step = 1'b0; ball_hit = 1'b0; wall_reset = 1'b0;
    line_strobe = 1'b0; frame_strobe = 1'b0; pix_en = 1'b1;
    run_frame(-1, -1, -1, -1, "R10");

    mid_fill = 1'b1;
    run_frame(4, 10, -1, -1, "R5");        // partial reset: rows 0..2 only
    run_frame(-1, -1, -1, -1, "R4");       // middle filled on rows 0..2
    mid_fill = 1'b0;
    run_frame(-1, -1, -1, -1, "R8");       // mode change keeps middle bits
    run_frame(4, 16, 15, 0, "R4");         // full reset with middle cleared, hit row 5
    run_frame(-1, -1, -1, -1, "R6");

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule